// File: doc/BRIEF.md
# Hotplug Slot Status Register Bank

This block is a small register window that a host reaches over a simple request/response port. It keeps insertion and removal state for a set of downstream buses, each of which has 32 slots. Every bus has three 32-bit masks: slots newly inserted, slots with a removal request pending, and slots that may be removed. A select register chooses the bus that the host sees through the window. Side inputs report plug and unplug notifications as a bus index plus a slot number. Each accepted notification produces a one-cycle event pulse toward the host.

The host acknowledges a removal by writing the eject register. Only the lowest set bit of the write data counts. That slot's bits are cleared on the selected bus, and an eject strobe carrying the bus and slot goes to the logic that detaches the device. A legacy flag makes the insert mask keep its value when it is read, and pins the bus select to bus 0. A platform reset pulse drains every pending removal, one eject per cycle. When the drain ends, the removable masks are reloaded from the per-bus fixed-slot input.

Top module: `hp_slot_bank`

## Requirements
- R1: After `rst`, on every bus the insert and removal masks read 0, the removable mask reads the inverse of that bus's `fixed_mask` slice, and the select register reads 0. `hp_event`, `eject_valid` and `drain_busy` are low.
- R2: A plug notification with `plug_boot` low sets bit `plug_slot` of the insert mask of bus `plug_bus`. It also gives `hp_event` high for exactly the cycle after it. With `plug_boot` high the notification changes nothing and gives no event.
- R3: An unplug notification sets bit `unplug_slot` of the removal mask of bus `unplug_bus` and gives `hp_event` high for the cycle after it.
- R4: A valid read at offset 0x0 returns the insert mask of the selected bus. When `legacy_mode` is low the read clears that mask. When `legacy_mode` is high the mask is left unchanged.
- R5: A valid write at offset 0x8 with nonzero data takes the lowest set data bit as the slot number. It clears that slot in both masks of the selected bus, and in the next cycle `eject_valid` pulses with `eject_bus` and `eject_slot` set. Write data of zero has no effect.
- R6: While the select value is not below NBUS, every read returns 0, and eject writes issue no strobe and clear nothing.
- R7: A write at offset 0x10 stores the write data in the select register, or 0 when `legacy_mode` is high. Offset 0x10 reads the select value. Offset 0x8 always reads 0. Offset 0x4 reads the removal mask and 0xC reads the removable mask.
- R8: An access counts only when `req_be` is 4'hF and `req_addr[1:0]` is 0. Any other access has no effect, and a read of that kind returns 0.
- R9: A plug notification overrides an eject write or an insert-mask read-clear that hits the same bus in the same cycle, so its slot bit stays set. The read still returns the mask value from before that cycle.
- R10: A `plat_reset` pulse raises `drain_busy`. The drain then ejects every pending removal one per cycle, going through the buses in ascending order and through each bus's bits lowest first. It clears each removal bit and its insert bit as it ejects it. It finishes by reloading each removable mask from `fixed_mask`, then drops `drain_busy`. Reads made during the drain return 0.
- R11: Every read request gives `rsp_valid` high in the cycle after it, with `rsp_rdata` carrying the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | Insert mask is not cleared on read; select is forced to 0 |
| fixed_mask | input | NBUS*32 | Non-removable slots, 32 bits per bus, bus 0 in the low bits |
| plat_reset | input | 1 | Pulse that starts the removal drain |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset in the window |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| plug_valid | input | 1 | Plug notification |
| plug_boot | input | 1 | Device present at boot, so no event |
| plug_bus | input | BUS_W | Bus of the plug notification |
| plug_slot | input | 5 | Slot of the plug notification |
| unplug_valid | input | 1 | Unplug notification |
| unplug_bus | input | BUS_W | Bus of the unplug notification |
| unplug_slot | input | 5 | Slot of the unplug notification |
| hp_event | output | 1 | One-cycle notification pulse |
| eject_valid | output | 1 | Eject strobe |
| eject_bus | output | BUS_W | Bus being ejected |
| eject_slot | output | 5 | Slot being ejected |
| drain_busy | output | 1 | Removal drain in progress |

## Verification
Plug notifications are swept over every slot of every bus, each followed by a read of the insert mask. This tells a wrong bit position or wrong bus steering apart from a missing read-clear. Unplugs set sparse, bus-dependent patterns, so a removal bit that leaks to another bus shows up. Eject writes use multi-bit data with the lowest bit at the bottom, in the middle and at the top, plus zero data, which tests the lowest-bit rule. Deliberate same-cycle collisions show which of the plug, the eject and the read-clear wins. The drain is checked against an ordered list of bus/slot pairs built from the bench's own mask model, and the fixed mask is changed beforehand so that the reload can be seen.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int SLOTS  = 32;
  localparam int SLOT_W = 5;
  localparam int DW     = 32;
  localparam int AW     = 5;

  // word index = req_addr[4:2]
  localparam logic [2:0] WRD_INS = 3'd0;
  localparam logic [2:0] WRD_REM = 3'd1;
  localparam logic [2:0] WRD_EJ  = 3'd2;
  localparam logic [2:0] WRD_EN  = 3'd3;
  localparam logic [2:0] WRD_SEL = 3'd4;

  function automatic logic [SLOTS-1:0] slot_bit(input logic [SLOT_W-1:0] s);
    return SLOTS'(1) << s;
  endfunction
endpackage

// File: rtl/hp_lowbit.sv
module hp_lowbit #(
  parameter int W  = 32,
  parameter int IW = 5
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/hp_bus_state.sv
module hp_bus_state #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] fixed_i,
  input  logic [W-1:0] set_up_i,
  input  logic [W-1:0] set_dn_i,
  input  logic [W-1:0] clr_i,
  input  logic         rd_clr_i,
  input  logic         reload_i,
  output logic [W-1:0] up_o,
  output logic [W-1:0] dn_o,
  output logic [W-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      up_o <= '0;
      dn_o <= '0;
      en_o <= ~fixed_i;
    end else begin
      // set terms applied last: a notification beats a clear
      up_o <= (up_o & ~clr_i & {W{~rd_clr_i}}) | set_up_i;
      dn_o <= (dn_o & ~clr_i) | set_dn_i;
      if (reload_i) en_o <= ~fixed_i;
    end
  end
endmodule

// File: rtl/hp_drain_seq.sv
module hp_drain_seq #(
  parameter int NBUS  = 4,
  parameter int BUS_W = 2,
  parameter int W     = 32,
  parameter int SW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [W-1:0]     dn_i [NBUS],
  output logic             busy_o,
  output logic             ej_valid_o,
  output logic [BUS_W-1:0] ej_bus_o,
  output logic [SW-1:0]    ej_slot_o,
  output logic             reload_o
);
  logic [BUS_W-1:0] ptr_q;
  logic [W-1:0]     cur;
  logic             any;
  logic [SW-1:0]    idx;
  logic             last;

  assign cur  = dn_i[ptr_q];
  assign last = (ptr_q == BUS_W'(NBUS - 1));

  hp_lowbit #(.W(W), .IW(SW)) u_low (.vec_i(cur), .any_o(any), .idx_o(idx));

  assign ej_valid_o = busy_o & any;
  assign ej_bus_o   = ptr_q;
  assign ej_slot_o  = idx;
  assign reload_o   = busy_o & ~any & last;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      ptr_q  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        ptr_q  <= '0;
      end
    end else if (!any) begin
      if (last) busy_o <= 1'b0;
      else      ptr_q  <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/hp_slot_bank.sv
module hp_slot_bank
  import hp_slot_pkg::*;
#(
  parameter int NBUS = 4,
  localparam int BUS_W = (NBUS > 1) ? $clog2(NBUS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  legacy_mode,
  input  logic [NBUS*SLOTS-1:0] fixed_mask,
  input  logic                  plat_reset,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [3:0]            req_be,
  input  logic [DW-1:0]         req_wdata,
  output logic                  rsp_valid,
  output logic [DW-1:0]         rsp_rdata,
  input  logic                  plug_valid,
  input  logic                  plug_boot,
  input  logic [BUS_W-1:0]      plug_bus,
  input  logic [SLOT_W-1:0]     plug_slot,
  input  logic                  unplug_valid,
  input  logic [BUS_W-1:0]      unplug_bus,
  input  logic [SLOT_W-1:0]     unplug_slot,
  output logic                  hp_event,
  output logic                  eject_valid,
  output logic [BUS_W-1:0]      eject_bus,
  output logic [SLOT_W-1:0]     eject_slot,
  output logic                  drain_busy
);
  localparam logic [BUS_W:0] NBUS_V = (BUS_W + 1)'(NBUS);

  logic [SLOTS-1:0] up_a [NBUS];
  logic [SLOTS-1:0] dn_a [NBUS];
  logic [SLOTS-1:0] en_a [NBUS];

  logic [DW-1:0]    sel_q;
  logic             sel_ok;
  logic [BUS_W-1:0] sel_idx;
  logic [2:0]       word;
  logic             acc_ok, rd_acc, wr_acc;
  logic             plug_hit, unplug_hit;

  assign sel_ok  = (sel_q < DW'(NBUS));
  assign sel_idx = sel_q[BUS_W-1:0];
  assign word    = req_addr[4:2];
  assign acc_ok  = req_valid && (req_be == 4'hF) && (req_addr[1:0] == 2'b00) && !drain_busy;
  assign rd_acc  = acc_ok && !req_write;
  assign wr_acc  = acc_ok && req_write;

  assign plug_hit   = plug_valid && !plug_boot && ({1'b0, plug_bus} < NBUS_V);
  assign unplug_hit = unplug_valid && ({1'b0, unplug_bus} < NBUS_V);

  // eject from a host write
  logic              wd_any;
  logic [SLOT_W-1:0] wd_slot;
  logic              wr_ej;
  hp_lowbit #(.W(DW), .IW(SLOT_W)) u_wlow (.vec_i(req_wdata), .any_o(wd_any), .idx_o(wd_slot));
  assign wr_ej = wr_acc && (word == WRD_EJ) && sel_ok && wd_any;

  // eject from the drain sequencer
  logic              dr_ej, dr_reload;
  logic [BUS_W-1:0]  dr_bus;
  logic [SLOT_W-1:0] dr_slot;
  hp_drain_seq #(.NBUS(NBUS), .BUS_W(BUS_W), .W(SLOTS), .SW(SLOT_W)) u_drain (
    .clk(clk), .rst(rst), .start_i(plat_reset), .dn_i(dn_a),
    .busy_o(drain_busy), .ej_valid_o(dr_ej), .ej_bus_o(dr_bus),
    .ej_slot_o(dr_slot), .reload_o(dr_reload)
  );

  logic              ej_go;
  logic [BUS_W-1:0]  ej_bus_c;
  logic [SLOT_W-1:0] ej_slot_c;
  assign ej_go     = wr_ej || dr_ej;
  assign ej_bus_c  = dr_ej ? dr_bus  : sel_idx;
  assign ej_slot_c = dr_ej ? dr_slot : wd_slot;

  generate
    for (genvar b = 0; b < NBUS; b++) begin : g_bus
      logic [SLOTS-1:0] set_up, set_dn, clr;
      logic             rd_clr;
      assign set_up = (plug_hit && plug_bus == BUS_W'(b)) ? slot_bit(plug_slot) : '0;
      assign set_dn = (unplug_hit && unplug_bus == BUS_W'(b)) ? slot_bit(unplug_slot) : '0;
      assign clr    = (ej_go && ej_bus_c == BUS_W'(b)) ? slot_bit(ej_slot_c) : '0;
      assign rd_clr = rd_acc && (word == WRD_INS) && sel_ok && !legacy_mode &&
                      (sel_idx == BUS_W'(b));
      hp_bus_state #(.W(SLOTS)) u_state (
        .clk(clk), .rst(rst), .fixed_i(fixed_mask[b*SLOTS +: SLOTS]),
        .set_up_i(set_up), .set_dn_i(set_dn), .clr_i(clr),
        .rd_clr_i(rd_clr), .reload_i(dr_reload),
        .up_o(up_a[b]), .dn_o(dn_a[b]), .en_o(en_a[b])
      );
    end
  endgenerate

  // select register
  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (wr_acc && word == WRD_SEL) sel_q <= legacy_mode ? '0 : req_wdata;
  end

  // read mux
  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (rd_acc && sel_ok) begin
      case (word)
        WRD_INS: rd_val = up_a[sel_idx];
        WRD_REM: rd_val = dn_a[sel_idx];
        WRD_EN:  rd_val = en_a[sel_idx];
        WRD_SEL: rd_val = sel_q;
        default: rd_val = '0;
      endcase
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      hp_event    <= 1'b0;
      eject_valid <= 1'b0;
      eject_bus   <= '0;
      eject_slot  <= '0;
    end else begin
      rsp_valid   <= req_valid && !req_write;
      rsp_rdata   <= rd_val;
      hp_event    <= plug_hit || unplug_hit;
      eject_valid <= ej_go;
      if (ej_go) begin
        eject_bus  <= ej_bus_c;
        eject_slot <= ej_slot_c;
      end
    end
  end
endmodule

// File: rtl/hp_slot_bank_chk.sv
module hp_slot_bank_chk #(
  parameter int NBUS  = 4,
  parameter int BUS_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_write,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic             plug_valid,
  input logic             plug_boot,
  input logic [BUS_W-1:0] plug_bus,
  input logic             unplug_valid,
  input logic [BUS_W-1:0] unplug_bus,
  input logic             hp_event,
  input logic             eject_valid,
  input logic             drain_busy
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!hp_event && !eject_valid && !drain_busy));

  // R2
  plug_event_chk: assert property (@(posedge clk) disable iff (rst)
    (plug_valid && !plug_boot && (int'(plug_bus) < NBUS)) |=> hp_event);

  // R3
  unplug_event_chk: assert property (@(posedge clk) disable iff (rst)
    (unplug_valid && (int'(unplug_bus) < NBUS)) |=> hp_event);

  // R5
  eject_cause_chk: assert property (@(posedge clk) disable iff (rst)
    eject_valid |-> $past(drain_busy || (req_valid && req_write)));

  // R10
  drain_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(drain_busy)) |-> (rsp_rdata == 32'h0));

  // R11
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  // R11
  rsp_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));
endmodule

bind hp_slot_bank hp_slot_bank_chk #(.NBUS(NBUS), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .plug_valid(plug_valid), .plug_boot(plug_boot), .plug_bus(plug_bus),
  .unplug_valid(unplug_valid), .unplug_bus(unplug_bus),
  .hp_event(hp_event), .eject_valid(eject_valid), .drain_busy(drain_busy)
);

// File: tb/hp_slot_bank_bench.sv
`timescale 1ns/1ps
module hp_slot_bank_bench;
  localparam int NB = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         legacy_mode = 1'b0;
  logic [127:0] fixed_mask;
  logic         plat_reset = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]   req_addr = '0;
  logic [3:0]   req_be = 4'hF;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         plug_valid = 1'b0, plug_boot = 1'b0;
  logic [1:0]   plug_bus = '0;
  logic [4:0]   plug_slot = '0;
  logic         unplug_valid = 1'b0;
  logic [1:0]   unplug_bus = '0;
  logic [4:0]   unplug_slot = '0;
  logic         hp_event, eject_valid, drain_busy;
  logic [1:0]   eject_bus;
  logic [4:0]   eject_slot;

  hp_slot_bank #(.NBUS(NB)) u_hp_slot_bank (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_dn [NB];
  logic [31:0] fixed_a [NB];
  logic [31:0] rd;
  logic        s_ev, s_ej;
  logic [1:0]  s_ejb;
  logic [4:0]  s_ejs;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lowbit(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic pack_fixed();
    for (int b = 0; b < NB; b++) fixed_mask[b*32 +: 32] = fixed_a[b];
  endtask

  task automatic rd_reg(input logic [4:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_be = be;
    @(posedge clk); #1;
    d = rsp_rdata;
    chk("R11 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    req_valid = 0; req_be = 4'hF;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk); #1;
    s_ej = eject_valid; s_ejb = eject_bus; s_ejs = eject_slot;
    req_valid = 0; req_write = 0; req_be = 4'hF;
  endtask

  task automatic notify(input bit is_plug, input int b, input int s, input bit boot);
    @(negedge clk);
    if (is_plug) begin
      plug_valid = 1; plug_boot = boot; plug_bus = 2'(b); plug_slot = 5'(s);
    end else begin
      unplug_valid = 1; unplug_bus = 2'(b); unplug_slot = 5'(s);
    end
    @(posedge clk); #1;
    s_ev = hp_event;
    plug_valid = 0; plug_boot = 0; unplug_valid = 0;
    @(posedge clk); #1;
    chk(is_plug ? "R2 event width" : "R3 event width", {31'b0, hp_event}, 32'h0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      fixed_a[b] = (32'h11 << (b * 4)) | 32'h8000_0000;
      exp_dn[b]  = '0;
    end
    pack_fixed();
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R1 reset state
    chk("R1 event", {31'b0, hp_event}, 0);
    chk("R1 eject", {31'b0, eject_valid}, 0);
    chk("R1 busy", {31'b0, drain_busy}, 0);
    rd_reg(5'h10, 4'hF, rd); chk("R1 select", rd, 0);
    for (int b = 0; b < NB; b++) begin
      wr_reg(5'h10, b, 4'hF);
      rd_reg(5'h00, 4'hF, rd); chk("R1 insert", rd, 0);
      rd_reg(5'h04, 4'hF, rd); chk("R1 removal", rd, 0);
      rd_reg(5'h0C, 4'hF, rd); chk("R1 removable", rd, ~fixed_a[b]);
      rd_reg(5'h10, 4'hF, rd); chk("R7 select read", rd, b);
    end

    // R2 R4 plug sweep with clear-on-read
    for (int b = 0; b < NB; b++) begin
      wr_reg(5'h10, b, 4'hF);
      for (int s = 0; s < 32; s++) begin
        notify(1, b, s, 0);
        chk("R2 event", {31'b0, s_ev}, 1);
        rd_reg(5'h00, 4'hF, rd); chk("R2 insert bit", rd, 32'h1 << s);
        rd_reg(5'h00, 4'hF, rd); chk("R4 cleared", rd, 0);
      end
      notify(1, b, 5, 1);
      chk("R2 boot no event", {31'b0, s_ev}, 0);
      rd_reg(5'h00, 4'hF, rd); chk("R2 boot no bit", rd, 0);
    end

    // R3 unplug patterns
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 32; s++)
        if ((s + b) % 3 == 0) begin
          notify(0, b, s, 0);
          chk("R3 event", {31'b0, s_ev}, 1);
          exp_dn[b][s] = 1'b1;
        end
    for (int b = 0; b < NB; b++) begin
      wr_reg(5'h10, b, 4'hF);
      rd_reg(5'h04, 4'hF, rd); chk("R3 removal mask", rd, exp_dn[b]);
    end

    // R4 R7 legacy mode
    legacy_mode = 1;
    wr_reg(5'h10, 2, 4'hF);
    rd_reg(5'h10, 4'hF, rd); chk("R7 legacy select", rd, 0);
    notify(1, 0, 3, 0);
    rd_reg(5'h00, 4'hF, rd); chk("R4 legacy read", rd, 32'h8);
    rd_reg(5'h00, 4'hF, rd); chk("R4 legacy kept", rd, 32'h8);
    legacy_mode = 0;
    rd_reg(5'h00, 4'hF, rd); chk("R4 read", rd, 32'h8);
    rd_reg(5'h00, 4'hF, rd); chk("R4 clear", rd, 0);

    // R5 eject lowest bit
    for (int b = 0; b < NB; b++) begin
      logic [31:0] pats [5];
      pats[0] = 32'h0; pats[1] = 32'h0000_0006; pats[2] = 32'h8000_0000;
      pats[3] = 32'hFFFF_FFF0; pats[4] = 32'h0000_0108 << b;
      wr_reg(5'h10, b, 4'hF);
      for (int p = 0; p < 5; p++) begin
        wr_reg(5'h08, pats[p], 4'hF);
        if (pats[p] == 0) begin
          chk("R5 zero data no strobe", {31'b0, s_ej}, 0);
        end else begin
          chk("R5 strobe", {31'b0, s_ej}, 1);
          chk("R5 bus", {30'b0, s_ejb}, b);
          chk("R5 slot", {27'b0, s_ejs}, lowbit(pats[p]));
          exp_dn[b][lowbit(pats[p])] = 1'b0;
        end
        rd_reg(5'h04, 4'hF, rd); chk("R5 removal after eject", rd, exp_dn[b]);
      end
    end

    // R7 R6 feature read and invalid select
    rd_reg(5'h08, 4'hF, rd); chk("R7 feature zero", rd, 0);
    wr_reg(5'h10, 5, 4'hF);
    rd_reg(5'h10, 4'hF, rd); chk("R6 select read zero", rd, 0);
    rd_reg(5'h0C, 4'hF, rd); chk("R6 removable read zero", rd, 0);
    rd_reg(5'h04, 4'hF, rd); chk("R6 removal read zero", rd, 0);
    wr_reg(5'h08, 32'hFFFF_FFFF, 4'hF);
    chk("R6 no strobe", {31'b0, s_ej}, 0);
    for (int b = 0; b < NB; b++) begin
      wr_reg(5'h10, b, 4'hF);
      rd_reg(5'h04, 4'hF, rd); chk("R6 masks untouched", rd, exp_dn[b]);
    end

    // R8 partial and misaligned accesses
    wr_reg(5'h10, 0, 4'hF);
    notify(1, 0, 12, 0);
    rd_reg(5'h01, 4'hF, rd); chk("R8 misaligned read", rd, 0);
    rd_reg(5'h00, 4'h7, rd); chk("R8 partial read", rd, 0);
    rd_reg(5'h00, 4'hF, rd); chk("R8 no clear by bad read", rd, 32'h1000);
    wr_reg(5'h10, 3, 4'h1);
    rd_reg(5'h10, 4'hF, rd); chk("R8 partial write ignored", rd, 0);
    wr_reg(5'h0A, 32'h1, 4'hF);
    chk("R8 misaligned eject ignored", {31'b0, s_ej}, 0);

    // R9 collisions
    wr_reg(5'h10, 1, 4'hF);
    notify(0, 1, 7, 0); exp_dn[1][7] = 1'b1;
    notify(1, 1, 7, 0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 5'h08; req_wdata = 32'h80;
    plug_valid = 1; plug_bus = 2'd1; plug_slot = 5'd7;
    @(posedge clk); #1;
    chk("R9 eject strobe", {31'b0, eject_valid}, 1);
    req_valid = 0; req_write = 0; plug_valid = 0;
    exp_dn[1][7] = 1'b0;
    rd_reg(5'h00, 4'hF, rd); chk("R9 plug beats eject", rd, 32'h80);
    rd_reg(5'h04, 4'hF, rd); chk("R9 removal cleared", rd, exp_dn[1]);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 5'h00;
    plug_valid = 1; plug_bus = 2'd1; plug_slot = 5'd9;
    @(posedge clk); #1;
    chk("R9 read old value", rsp_rdata, 0);
    req_valid = 0; plug_valid = 0;
    rd_reg(5'h00, 4'hF, rd); chk("R9 plug beats read-clear", rd, 32'h200);

    // R10 drain
    notify(1, 2, 31, 0);
    notify(0, 2, 31, 0); exp_dn[2][31] = 1'b1;
    notify(0, 3, 4, 0);  exp_dn[3][4] = 1'b1;
    for (int b = 0; b < NB; b++) fixed_a[b] = 32'h0000_0F00 >> b;
    pack_fixed();
    wr_reg(5'h10, 0, 4'hF);
    rd_reg(5'h0C, 4'hF, rd);
    chk("R10 no reload before drain", rd, ~((32'h11) | 32'h8000_0000));
    begin
      logic [6:0] seq [128];
      int n_exp = 0, n_got = 0;
      for (int b = 0; b < NB; b++)
        for (int s = 0; s < 32; s++)
          if (exp_dn[b][s]) begin seq[n_exp] = {2'(b), 5'(s)}; n_exp++; end
      @(negedge clk); plat_reset = 1;
      @(posedge clk); #1; plat_reset = 0;
      chk("R10 busy", {31'b0, drain_busy}, 1);
      for (int c = 0; c < 400 && drain_busy; c++) begin
        @(negedge clk);
        if (c == 1) begin req_valid = 1; req_write = 0; req_addr = 5'h0C; end
        else req_valid = 0;
        @(posedge clk); #1;
        if (eject_valid) begin
          if (n_got < n_exp) chk("R10 eject order", {25'b0, eject_bus, eject_slot},
                                 {25'b0, seq[n_got]});
          n_got++;
        end
        if (c == 1) chk("R10 read during drain", rsp_rdata, 0);
      end
      req_valid = 0;
      chk("R10 eject count", n_got, n_exp);
      chk("R10 done", {31'b0, drain_busy}, 0);
    end
    for (int b = 0; b < NB; b++) begin
      wr_reg(5'h10, b, 4'hF);
      rd_reg(5'h04, 4'hF, rd); chk("R10 removal empty", rd, 0);
      rd_reg(5'h0C, 4'hF, rd); chk("R10 removable reloaded", rd, ~fixed_a[b]);
    end
    wr_reg(5'h10, 2, 4'hF);
    rd_reg(5'h00, 4'hF, rd); chk("R10 insert bit cleared", rd, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule